// File: doc/BRIEF.md
# Timer Interrupt Router and Status

This block takes the match events of up to 32 timer channels and turns them into interrupt activity. Each channel brings its own enable, a trigger-type bit choosing level or edge behaviour, a 5-bit line selector and a message-route enable. A level channel latches a pending bit in a shared status vector and holds its selected line high until software clears the bit by writing a one to it. An edge channel gives a one-cycle pulse on its line and leaves the status vector alone. A channel set to message routing drives no line. Instead, each of its matches produces one output strobe that carries a 32-bit address and a 32-bit data word, both taken from that channel's 64-bit message configuration.

A legacy replacement mode moves channels 0 and 1 onto fixed lines. It also takes over the line that normally forwards an external real-time-clock interrupt. When legacy mode is off, that external level passes through to the same line. Each interrupt line is the OR of every channel that drives it, together with the forwarded clock interrupt.

Top module: `tir_irq_router`

## Requirements
- R1: With `legacy_en` high, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R2: Every other channel, and channels 0 and 1 when `legacy_en` is low, drives the line numbered by its 5-bit field `ch_route[5*i +: 5]`. A line is high while any channel driving it is active.
- R3: A match on an enabled level channel (`ch_level[i]`=1, message routing off, `glb_en`=1) sets `irq_status[i]` on the next clock edge. The channel's line then stays high until the bit is cleared.
- R4: A match on an enabled edge channel (`ch_level[i]`=0) raises its line for exactly one cycle, starting at the next clock edge, and does not set `irq_status[i]`.
- R5: A cycle with `sts_wr` high clears every status bit whose `sts_wdata` bit is 1 and lowers the matching lines. Ones written at bits that are not pending change nothing. A level match in the same cycle as a clear of that channel leaves the bit set.
- R6: While `ch_en[i]` or `glb_en` is low, `irq_status[i]` is cleared on the next edge and the channel drives no line.
- R7: A match on an enabled channel with `ch_msg_en[i]`=1 drives no line. Two edges later it produces a one-cycle `msg_valid`, with `msg_addr` = `ch_msg_cfg[64*i+32 +: 32]` and `msg_data` = `ch_msg_cfg[64*i +: 32]`.
- R8: Messages from several channels are issued one per cycle, lowest channel index first.
- R9: When `ch_msg_en[i]` goes from 0 to 1, a pending `irq_status[i]` is cleared on the next edge and its line drops at once.
- R10: With `legacy_en` low, the registered `rtc_irq_in` level drives line 8. With `legacy_en` high, the level is held back. Turning legacy mode off again restores the current level.
- R11: After reset, all lines, all status bits and `msg_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable for all channels |
| legacy_en | input | 1 | Legacy replacement routing mode |
| ch_en | input | NCH | Per-channel enable |
| ch_level | input | NCH | 1 = level trigger, 0 = edge trigger |
| ch_msg_en | input | NCH | Per-channel message-route select |
| ch_route | input | NCH*RW | Line selector per channel |
| ch_msg_cfg | input | NCH*64 | Per channel: address in the high 32 bits, data in the low 32 bits |
| ch_match | input | NCH | One-cycle match event per channel |
| sts_wr | input | 1 | Status clear write strobe |
| sts_wdata | input | NCH | Bits to clear (write one to clear) |
| rtc_irq_in | input | 1 | External real-time-clock interrupt level |
| irq_lines | output | 2**RW | Interrupt line vector |
| irq_status | output | NCH | Pending bits of level channels |
| msg_valid | output | 1 | Message strobe |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Two events can fall in the same cycle: a software clear of a pending status bit, and a new level match on that same channel. The bench makes channel 3 pending. It then raises its match in the same cycle as a status write with bit 3 set, and expects the bit to remain set and line 4 to stay high. A second case puts two message matches in one cycle. The bench then requires channel 6's strobe in the first cycle and channel 9's in the next, with the right address and data in each.

// File: rtl/tir_pkg.sv
// Package: shared types for the timer interrupt router.
// Assumes a message configuration word holds the address in its upper half
// and the data word in its lower half.
package tir_pkg;
    localparam int MSG_W = 32;

    typedef struct packed {
        logic [MSG_W-1:0] addr;
        logic [MSG_W-1:0] data;
    } tir_msg_t;
endpackage

// File: rtl/tir_chan.sv
// Module: tir_chan
// One timer channel slice. It holds the pending bit for level channels,
// makes the one-cycle pulse for edge channels and keeps a message request
// until the arbiter grants it.
// Assumes: match is a single-cycle event and grant is one-hot across slices.
module tir_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic glb_en,
    input  logic en,
    input  logic level,
    input  logic msg_en,
    input  logic match,
    input  logic clr,
    input  logic grant,
    output logic status,
    output logic msg_req,
    output logic drive
);
    logic active;
    logic msg_en_q;
    logic pulse_q;
    logic lvl_hit;
    logic edge_hit;
    logic msg_hit;

    // Qualify the match event by enables and delivery kind
    always_comb begin
        active   = en & glb_en;
        lvl_hit  = match & active & level & ~msg_en;
        edge_hit = match & active & ~level & ~msg_en;
        msg_hit  = match & active & msg_en;
    end

    // State update: pending bit, edge pulse, message request, enable history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status   <= 1'b0;
            pulse_q  <= 1'b0;
            msg_req  <= 1'b0;
            msg_en_q <= 1'b0;
        end else begin
            msg_en_q <= msg_en;
            pulse_q  <= edge_hit;
            if (!active || (msg_en && !msg_en_q))
                status <= 1'b0;
            else
                status <= (status & ~clr) | lvl_hit;
            if (!active)
                msg_req <= 1'b0;
            else
                msg_req <= (msg_req & ~grant) | msg_hit;
        end
    end

    // Line drive: pending level or edge pulse, never while message-routed
    always_comb drive = (status | pulse_q) & ~msg_en;

    a_r3_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_hit |=> status);
    a_r4_edge_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && !status) |=> !status);
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !lvl_hit) |=> !status);
    a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !status);
    a_r9_msg_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_en) |=> !status);
endmodule

// File: rtl/tir_line_mux.sv
// Module: tir_line_mux
// Maps each channel's drive onto its effective interrupt line, ORs the
// contributions per line, and forwards the clock interrupt when legacy
// mode is off.
// Assumes RTC_LINE < 2**RW.
module tir_line_mux #(
    parameter int NCH      = 32,
    parameter int RW       = 5,
    parameter int RTC_LINE = 8,
    localparam int NL      = 1 << RW
) (
    input  logic [NCH-1:0]    drive,
    input  logic [NCH*RW-1:0] route,
    input  logic              legacy,
    input  logic              rtc_lvl,
    output logic [NL-1:0]     lines
);
    localparam logic [RW-1:0] RTC_IDX = RW'(RTC_LINE);

    // Effective line of a channel given legacy override
    function automatic logic [RW-1:0] eff_route(input int idx,
                                                input logic [RW-1:0] cfg,
                                                input logic leg);
        if (leg && idx == 0) return '0;
        if (leg && idx == 1) return RTC_IDX;
        return cfg;
    endfunction

    // OR-combine all channel drives and the forwarded clock interrupt
    always_comb begin
        lines = '0;
        for (int i = 0; i < NCH; i++) begin
            if (drive[i])
                lines[eff_route(i, route[i*RW +: RW], legacy)] = 1'b1;
        end
        if (!legacy && rtc_lvl)
            lines[RTC_LINE] = 1'b1;
    end
endmodule

// File: rtl/tir_msg_arb.sv
// Module: tir_msg_arb
// Fixed-priority arbiter for message requests: the lowest index wins and one
// message is registered out per cycle.
// Assumes each channel's config is stable while its request is pending.
module tir_msg_arb
    import tir_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req,
    input  logic [NCH*64-1:0] cfg,
    output logic [NCH-1:0]   grant,
    output logic             msg_valid,
    output logic [MSG_W-1:0] msg_addr,
    output logic [MSG_W-1:0] msg_data
);
    tir_msg_t sel;
    logic     found;

    // Lowest-index grant and selection of its configuration word
    always_comb begin
        grant = '0;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
                sel      = tir_msg_t'(cfg[i*64 +: 64]);
            end
        end
    end

    // Register the strobe and its payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else begin
            msg_valid <= found;
            if (found) begin
                msg_addr <= sel.addr;
                msg_data <= sel.data;
            end
        end
    end

    a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r7_req_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> msg_valid);
endmodule

// File: rtl/tir_irq_router.sv
// Module: tir_irq_router (top)
// Interrupt delivery for NCH timer channels: status latching, line routing
// with legacy override, clock interrupt pass-through and message strobes.
// Assumes all inputs are synchronous to clk.
module tir_irq_router
    import tir_pkg::*;
#(
    parameter int NCH      = 32,
    parameter int RW       = 5,
    parameter int RTC_LINE = 8,
    localparam int NL      = 1 << RW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              legacy_en,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_level,
    input  logic [NCH-1:0]    ch_msg_en,
    input  logic [NCH*RW-1:0] ch_route,
    input  logic [NCH*64-1:0] ch_msg_cfg,
    input  logic [NCH-1:0]    ch_match,
    input  logic              sts_wr,
    input  logic [NCH-1:0]    sts_wdata,
    input  logic              rtc_irq_in,
    output logic [NL-1:0]     irq_lines,
    output logic [NCH-1:0]    irq_status,
    output logic              msg_valid,
    output logic [MSG_W-1:0]  msg_addr,
    output logic [MSG_W-1:0]  msg_data
);
    logic [NCH-1:0] drive;
    logic [NCH-1:0] req;
    logic [NCH-1:0] grant;
    logic           rtc_q;

    // Remember the external clock interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) rtc_q <= 1'b0;
        else        rtc_q <= rtc_irq_in;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        tir_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .glb_en  (glb_en),
            .en      (ch_en[g]),
            .level   (ch_level[g]),
            .msg_en  (ch_msg_en[g]),
            .match   (ch_match[g]),
            .clr     (sts_wr & sts_wdata[g]),
            .grant   (grant[g]),
            .status  (irq_status[g]),
            .msg_req (req[g]),
            .drive   (drive[g])
        );
    end

    tir_line_mux #(.NCH(NCH), .RW(RW), .RTC_LINE(RTC_LINE)) u_mux (
        .drive   (drive),
        .route   (ch_route),
        .legacy  (legacy_en),
        .rtc_lvl (rtc_q),
        .lines   (irq_lines)
    );

    tir_msg_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .cfg       (ch_msg_cfg),
        .grant     (grant),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    a_r1_legacy_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_en && drive[0]) |-> irq_lines[0]);
    a_r1_legacy_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_en && drive[1]) |-> irq_lines[RTC_LINE]);
    a_r10_rtc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_en && rtc_q) |-> irq_lines[RTC_LINE]);
    a_r7_msg_no_line: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_msg_en[0] && !legacy_en && !rtc_q && !(|(drive & ~1))) |-> (irq_lines == '0));
endmodule

// File: tb/sim_tir_irq_router.sv
`timescale 1ns/100ps
module sim_tir_irq_router;
    localparam int NCH = 32;
    localparam int RW  = 5;
    localparam int NL  = 32;

    logic              clk = 0;
    logic              rst_n;
    logic              glb_en, legacy_en;
    logic [NCH-1:0]    ch_en, ch_level, ch_msg_en, ch_match, sts_wdata;
    logic [NCH*RW-1:0] ch_route;
    logic [NCH*64-1:0] ch_msg_cfg;
    logic              sts_wr, rtc_irq_in;
    logic [NL-1:0]     irq_lines;
    logic [NCH-1:0]    irq_status;
    logic              msg_valid;
    logic [31:0]       msg_addr, msg_data;

    int checks = 0;
    int errors = 0;

    // Fields: legacy, level, channel[5], route[5], expected line[5]
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 1'b1, 5'd0,  5'd3,  5'd3},
        {1'b0, 1'b0, 5'd5,  5'd17, 5'd17},
        {1'b1, 1'b1, 5'd0,  5'd9,  5'd0},
        {1'b1, 1'b0, 5'd1,  5'd2,  5'd8},
        {1'b1, 1'b1, 5'd2,  5'd20, 5'd20},
        {1'b0, 1'b1, 5'd1,  5'd2,  5'd2},
        {1'b0, 1'b0, 5'd31, 5'd31, 5'd31},
        {1'b0, 1'b1, 5'd17, 5'd8,  5'd8}
    };

    always #2.5 clk = ~clk;

    tir_irq_router u0 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_en(legacy_en),
        .ch_en(ch_en), .ch_level(ch_level), .ch_msg_en(ch_msg_en),
        .ch_route(ch_route), .ch_msg_cfg(ch_msg_cfg), .ch_match(ch_match),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .rtc_irq_in(rtc_irq_in),
        .irq_lines(irq_lines), .irq_status(irq_status), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        sts_wr = 1; sts_wdata = '1;
        tick();
        sts_wr = 0; sts_wdata = '0;
    endtask

    initial begin
        #(200_000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; glb_en = 0; legacy_en = 0; ch_en = '0; ch_level = '0;
        ch_msg_en = '0; ch_match = '0; sts_wdata = '0; sts_wr = 0;
        ch_route = '0; ch_msg_cfg = '0; rtc_irq_in = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R11 reset state
        chk(irq_lines == '0, "R11", 64'(irq_lines), 64'h0);
        chk(irq_status == '0, "R11", 64'(irq_status), 64'h0);
        chk(msg_valid == 1'b0, "R11", 64'(msg_valid), 64'h0);

        glb_en = 1;
        // Table walk: R1/R2 routing, R3 level, R4 edge, R5 clear
        for (int v = 0; v < 8; v++) begin
            logic lg, lv;
            int ch, rt, ex;
            lg = VEC[v][16]; lv = VEC[v][15]; ch = VEC[v][14:10];
            rt = VEC[v][9:5]; ex = VEC[v][4:0];
            ch_en = '0; ch_en[ch] = 1'b1; ch_level[ch] = lv;
            ch_route[ch*RW +: RW] = RW'(rt); legacy_en = lg;
            ch_match[ch] = 1'b1;
            tick();
            ch_match = '0;
            chk(irq_lines == (NL'(1) << ex), (lg && ch < 2) ? "R1" : "R2",
                64'(irq_lines), 64'(NL'(1) << ex));
            chk(irq_status == (lv ? (NCH'(1) << ch) : '0), lv ? "R3" : "R4",
                64'(irq_status), 64'(lv ? (NCH'(1) << ch) : '0));
            if (lv) begin
                sts_wr = 1; sts_wdata = NCH'(1) << ch;
                tick();
                sts_wr = 0; sts_wdata = '0;
                chk(irq_status == '0 && irq_lines == '0, "R5",
                    64'(irq_lines), 64'h0);
            end else begin
                tick();
                chk(irq_lines == '0, "R4", 64'(irq_lines), 64'h0);
            end
        end
        legacy_en = 0;

        // R5: writing one at a non-pending bit changes nothing
        ch_en = '0; ch_en[3] = 1; ch_level[3] = 1; ch_route[3*RW +: RW] = 5'd4;
        ch_match[3] = 1; tick(); ch_match = '0;
        sts_wr = 1; sts_wdata = NCH'(1) << 7; tick(); sts_wr = 0; sts_wdata = '0;
        chk(irq_status == (NCH'(1) << 3), "R5", 64'(irq_status), 64'h8);
        chk(irq_lines == (NL'(1) << 4), "R5", 64'(irq_lines), 64'h10);

        // R5: clear and new level match in the same cycle, set wins
        ch_match[3] = 1; sts_wr = 1; sts_wdata = NCH'(1) << 3;
        tick();
        ch_match = '0; sts_wr = 0; sts_wdata = '0;
        chk(irq_status == (NCH'(1) << 3), "R5", 64'(irq_status), 64'h8);
        chk(irq_lines == (NL'(1) << 4), "R5", 64'(irq_lines), 64'h10);

        // R6: channel disable clears pending
        ch_en[3] = 0; tick();
        chk(irq_status == '0 && irq_lines == '0, "R6", 64'(irq_status), 64'h0);

        // R6: global disable clears pending
        ch_en[3] = 1; ch_match[3] = 1; tick(); ch_match = '0;
        glb_en = 0; tick();
        chk(irq_status == '0 && irq_lines == '0, "R6", 64'(irq_status), 64'h0);
        glb_en = 1;
        clear_all();

        // R7: message path
        ch_en = '0; ch_en[6] = 1; ch_msg_en[6] = 1;
        ch_msg_cfg[6*64 +: 64] = {32'h8000_1234, 32'hCAFE_0006};
        ch_en[9] = 1; ch_msg_en[9] = 1;
        ch_msg_cfg[9*64 +: 64] = {32'h9000_0009, 32'hD00D_0009};
        tick();
        ch_match[6] = 1; tick(); ch_match = '0;
        chk(irq_lines == '0 && msg_valid == 0, "R7", 64'(irq_lines), 64'h0);
        tick();
        chk(msg_valid == 1, "R7", 64'(msg_valid), 64'h1);
        chk(msg_addr == 32'h8000_1234 && msg_data == 32'hCAFE_0006, "R7",
            {msg_addr, msg_data}, 64'h8000_1234_CAFE_0006);
        tick();
        chk(msg_valid == 0, "R7", 64'(msg_valid), 64'h0);

        // R8: two messages in one cycle, lowest index first
        ch_match[6] = 1; ch_match[9] = 1; tick(); ch_match = '0;
        tick();
        chk(msg_valid == 1 && msg_data == 32'hCAFE_0006, "R8",
            64'(msg_data), 64'hCAFE_0006);
        tick();
        chk(msg_valid == 1 && msg_addr == 32'h9000_0009 && msg_data == 32'hD00D_0009,
            "R8", {msg_addr, msg_data}, 64'h9000_0009_D00D_0009);
        tick();
        chk(msg_valid == 0, "R8", 64'(msg_valid), 64'h0);

        // R9: message-route enable rising clears pending
        ch_en[2] = 1; ch_level[2] = 1; ch_route[2*RW +: RW] = 5'd7;
        ch_match[2] = 1; tick(); ch_match = '0;
        chk(irq_status == (NCH'(1) << 2), "R9", 64'(irq_status), 64'h4);
        ch_msg_en[2] = 1; tick();
        chk(irq_status == '0 && irq_lines == '0, "R9", 64'(irq_status), 64'h0);

        // R10: clock interrupt pass-through and legacy hold-back
        ch_en = '0; ch_msg_en = '0;
        rtc_irq_in = 1; tick();
        chk(irq_lines == (NL'(1) << 8), "R10", 64'(irq_lines), 64'h100);
        legacy_en = 1; tick();
        chk(irq_lines == '0, "R10", 64'(irq_lines), 64'h0);
        rtc_irq_in = 0; tick(); rtc_irq_in = 1; tick();
        legacy_en = 0; tick();
        chk(irq_lines == (NL'(1) << 8), "R10", 64'(irq_lines), 64'h100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule